// File: doc/BRIEF.md
# Nibble Accumulator ALU with Carry, Zero and Skip

This block is the arithmetic core of a small accumulator machine. Each instruction slot supplies an operation code, the current accumulator value, one operand nibble (taken from data memory or from the instruction literal) and, for bit tests, a bit index. The block returns the result nibble at once, with strobes that say whether the result goes to the accumulator or back to memory. It holds the carry and zero flags, which change at the clock edge that ends the slot.

The carry flag also serves as the inverted borrow. Subtraction consumes it as "no borrow pending" and sets it again when the difference is not negative. Each operation touches only its own flags: logic operations leave the carry alone, plain rotates and stores touch neither flag, and the compare operations only evaluate a condition.

A true compare condition does not branch. It arms a registered skip, and the next instruction slot is then executed as a no-op: no write strobe, no flag change and no new skip. A condition supplied from outside (for example a playback status) can also arm the skip.

Top module: `nib_alu_core`

## Requirements
- R1: While reset is asserted and after it is released, carry_o, zero_o and skip_o read 0, and both write strobes are 0 while op_valid_i is low.
- R2: Operation code 1 (add) gives res_o = acc + opnd + carry, modulo 16, with acc_we_o set. The carry becomes the carry-out, and zero becomes 1 exactly when the 4-bit result is 0.
- R3: Operation code 2 (subtract) gives res_o = acc − opnd − (1 − carry), modulo 16, with acc_we_o set. The carry becomes 1 when that difference is zero or positive and 0 on a borrow. Zero follows the result.
- R4: Operation codes 3 (AND), 4 (OR) and 5 (XOR) combine acc with opnd into the accumulator and update zero only. The carry keeps its value.
- R5: Operation code 6 rotates acc right through the carry as a 5-bit ring: the result is {carry, acc[3:1]} and the new carry is acc[0]. Operation code 7 rotates left: the result is {acc[2:0], carry} and the new carry is acc[3]. Both update zero.
- R6: Operation codes 8 (rotate right, result {acc[0], acc[3:1]}) and 9 (rotate left, result {acc[2:0], acc[3]}) write the accumulator and change neither flag.
- R7: Operation code 10 (increment) and code 11 (decrement) write opnd ± 1, modulo 16, through mem_we_o only. Increment sets the carry when opnd was 15. Decrement clears the carry when opnd was 0 and sets it otherwise. Both update zero.
- R8: Operation code 12 copies acc to memory without touching flags. Code 13 copies opnd to the accumulator and updates zero only. Code 14 sets the carry and code 15 clears it, with no write strobe.
- R9: Operation codes 16 (acc > opnd), 17 (acc < opnd) and 18 (acc ≠ opnd) compare unsigned values. When the condition holds, skip_o rises after the edge. These codes write nothing and change no flag.
- R10: Operation codes 19 (carry = 0), 20 (zero = 0), 21 (carry = 1), 22 (zero = 1), 23 (acc bit bit_sel_i = 0) and 24 (ext_skip_i = 1) arm the skip when their condition holds, with no write and no flag change.
- R11: With skip_o high, the next slot with op_valid_i high is nullified. Both write strobes are 0, the flags keep their values, no new skip is armed, and skip_o returns to 0 after that edge. The slot after it executes normally.
- R12: While op_valid_i is low, both write strobes are 0 and carry_o, zero_o and skip_o keep their values across edges.
- R13: Operation codes 0 and 25 to 31 write nothing, keep both flags and arm no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| op_valid_i | input | 1 | An instruction occupies this slot |
| op_i | input | 5 | Operation code |
| acc_i | input | DATA_W | Current accumulator value |
| opnd_i | input | DATA_W | Memory or literal operand |
| bit_sel_i | input | BIT_W | Bit index for the bit test |
| ext_skip_i | input | 1 | External skip condition (code 24) |
| res_o | output | DATA_W | Result nibble |
| acc_we_o | output | 1 | Write res_o to the accumulator |
| mem_we_o | output | 1 | Write res_o to memory |
| carry_o | output | 1 | Carry flag (inverted borrow) |
| zero_o | output | 1 | Zero flag |
| skip_o | output | 1 | The next slot will be nullified |

## Verification
The bench builds the block with its defaults: DATA_W of 4, so BIT_W is 2, and a 5-bit operation code. At that width, add and subtract can be swept over every accumulator value, every operand value and both carry inputs, so every carry-out and borrow boundary is reached. The small code space also lets the bench drive every unused code. Rotates, the increment and decrement wrap points, each skip condition in both polarities, a skip held across idle slots, and a skip that lands on another skip are each driven by their own task.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_RRC   = 5'd6,
    OP_RLC   = 5'd7,
    OP_RR    = 5'd8,
    OP_RL    = 5'd9,
    OP_INC   = 5'd10,
    OP_DEC   = 5'd11,
    OP_MOVAM = 5'd12,
    OP_MOVMA = 5'd13,
    OP_SETC  = 5'd14,
    OP_CLRC  = 5'd15,
    OP_SKGT  = 5'd16,
    OP_SKLT  = 5'd17,
    OP_SKNE  = 5'd18,
    OP_SKC0  = 5'd19,
    OP_SKZ0  = 5'd20,
    OP_SKC1  = 5'd21,
    OP_SKZ1  = 5'd22,
    OP_SKB0  = 5'd23,
    OP_SKEXT = 5'd24
  } alu_op_e;

  typedef struct packed {
    logic acc_we;
    logic mem_we;
    logic c_we;
    logic z_we;
  } wr_ctl_t;

endpackage

// File: rtl/nib_alu_decode.sv
module nib_alu_decode
  import nib_alu_pkg::*;
(
  input  alu_op_e op_i,
  output wr_ctl_t ctl_o,
  output logic    is_skip_o
);

  always_comb begin
    ctl_o     = '0;
    is_skip_o = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB, OP_RRC, OP_RLC: begin
        ctl_o.acc_we = 1'b1;
        ctl_o.c_we   = 1'b1;
        ctl_o.z_we   = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_MOVMA: begin
        ctl_o.acc_we = 1'b1;
        ctl_o.z_we   = 1'b1;
      end
      OP_RR, OP_RL: ctl_o.acc_we = 1'b1;
      OP_INC, OP_DEC: begin
        ctl_o.mem_we = 1'b1;
        ctl_o.c_we   = 1'b1;
        ctl_o.z_we   = 1'b1;
      end
      OP_MOVAM:         ctl_o.mem_we = 1'b1;
      OP_SETC, OP_CLRC: ctl_o.c_we   = 1'b1;
      OP_SKGT, OP_SKLT, OP_SKNE, OP_SKC0, OP_SKZ0,
      OP_SKC1, OP_SKZ1, OP_SKB0, OP_SKEXT: is_skip_o = 1'b1;
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/nib_alu_datapath.sv
module nib_alu_datapath
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);

  localparam int unsigned SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] add_a, add_b, add_c, add_sum;
  logic [DATA_W-1:0] ones;

  assign ones = {DATA_W{1'b1}};

  // one shared adder; subtract and decrement feed it inverted or all-ones
  always_comb begin
    add_a = {1'b0, acc_i};
    add_b = {1'b0, opnd_i};
    add_c = {{DATA_W{1'b0}}, cin_i};
    case (op_i)
      OP_SUB: add_b = {1'b0, ~opnd_i};
      OP_INC: begin
        add_a = {1'b0, opnd_i};
        add_b = '0;
        add_c = {{DATA_W{1'b0}}, 1'b1};
      end
      OP_DEC: begin
        add_a = {1'b0, opnd_i};
        add_b = {1'b0, ones};
        add_c = '0;
      end
      default: ;
    endcase
  end

  assign add_sum = add_a + add_b + add_c;

  always_comb begin
    res_o  = '0;
    cout_o = cin_i;
    case (op_i)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        res_o  = add_sum[DATA_W-1:0];
        cout_o = add_sum[DATA_W];
      end
      OP_AND:   res_o = acc_i & opnd_i;
      OP_OR:    res_o = acc_i | opnd_i;
      OP_XOR:   res_o = acc_i ^ opnd_i;
      OP_RRC: begin
        res_o  = {cin_i, acc_i[DATA_W-1:1]};
        cout_o = acc_i[0];
      end
      OP_RLC: begin
        res_o  = {acc_i[DATA_W-2:0], cin_i};
        cout_o = acc_i[DATA_W-1];
      end
      OP_RR:    res_o = {acc_i[0], acc_i[DATA_W-1:1]};
      OP_RL:    res_o = {acc_i[DATA_W-2:0], acc_i[DATA_W-1]};
      OP_MOVAM: res_o = acc_i;
      OP_MOVMA: res_o = opnd_i;
      OP_SETC:  cout_o = 1'b1;
      OP_CLRC:  cout_o = 1'b0;
      default: begin
        res_o  = '0;
        cout_o = cin_i;
      end
    endcase
  end

endmodule

// File: rtl/nib_alu_cond.sv
module nib_alu_cond
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned BIT_W  = 2
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              ext_i,
  output logic              hit_o
);

  always_comb begin
    case (op_i)
      OP_SKGT:  hit_o = acc_i > opnd_i;
      OP_SKLT:  hit_o = acc_i < opnd_i;
      OP_SKNE:  hit_o = acc_i != opnd_i;
      OP_SKC0:  hit_o = ~c_i;
      OP_SKZ0:  hit_o = ~z_i;
      OP_SKC1:  hit_o = c_i;
      OP_SKZ1:  hit_o = z_i;
      OP_SKB0:  hit_o = ~acc_i[bit_sel_i];
      OP_SKEXT: hit_o = ext_i;
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nib_alu_state.sv
module nib_alu_state (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid_i,
  input  logic c_we_i,
  input  logic z_we_i,
  input  logic c_nxt_i,
  input  logic z_nxt_i,
  input  logic skip_req_i,
  output logic c_q,
  output logic z_q,
  output logic skip_q,
  output logic exec_o
);

  logic c_d, z_d, skip_d;

  assign exec_o = op_valid_i & ~skip_q;

  always_comb begin
    c_d    = c_q;
    z_d    = z_q;
    skip_d = 1'b0;
    if (!skip_q) begin
      if (c_we_i) c_d = c_nxt_i;
      if (z_we_i) z_d = z_nxt_i;
      skip_d = skip_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= 1'b0;
      z_q    <= 1'b0;
      skip_q <= 1'b0;
    end else if (op_valid_i) begin
      c_q    <= c_d;
      z_q    <= z_d;
      skip_q <= skip_d;
    end
  end

  assert_skip_one_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && op_valid_i) |=> !skip_q);

  assert_nullify_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && op_valid_i) |=> ($stable(c_q) && $stable(z_q)));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> ($stable(c_q) && $stable(z_q) && $stable(skip_q)));

endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  logic              ext_skip_i,
  output logic [DATA_W-1:0] res_o,
  output logic              acc_we_o,
  output logic              mem_we_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              skip_o
);

  alu_op_e     op;
  wr_ctl_t     ctl;
  logic        skip_op, cond_hit, cout, exec;
  logic [DATA_W-1:0] res;

  assign op = alu_op_e'(op_i);

  nib_alu_decode i_decode (
    .op_i      (op),
    .ctl_o     (ctl),
    .is_skip_o (skip_op)
  );

  nib_alu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .op_i   (op),
    .acc_i  (acc_i),
    .opnd_i (opnd_i),
    .cin_i  (carry_o),
    .res_o  (res),
    .cout_o (cout)
  );

  nib_alu_cond #(.DATA_W(DATA_W), .BIT_W(BIT_W)) i_cond (
    .op_i      (op),
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .bit_sel_i (bit_sel_i),
    .c_i       (carry_o),
    .z_i       (zero_o),
    .ext_i     (ext_skip_i),
    .hit_o     (cond_hit)
  );

  nib_alu_state i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .c_we_i     (ctl.c_we),
    .z_we_i     (ctl.z_we),
    .c_nxt_i    (cout),
    .z_nxt_i    (res == '0),
    .skip_req_i (skip_op & cond_hit),
    .c_q        (carry_o),
    .z_q        (zero_o),
    .skip_q     (skip_o),
    .exec_o     (exec)
  );

  assign res_o    = res;
  assign acc_we_o = exec & ctl.acc_we;
  assign mem_we_o = exec & ctl.mem_we;

  // R2..R8: zero flag mirrors the nibble written in the slot that updated it
  assert_zero_tracks_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && ctl.z_we) |=> (zero_o == ($past(res_o) == '0)));

  assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> $stable(carry_o));

  assert_plain_rotate_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_RR || op == OP_RL)) |=> ($stable(carry_o) && $stable(zero_o)));

  assert_inc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_INC) |=> (carry_o == ($past(opnd_i) == {DATA_W{1'b1}})));

  assert_compare_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && skip_op) |=> ($stable(carry_o) && $stable(zero_o)));

  always_comb begin
    if (rst_n && op_valid_i && skip_o)
      assert_nullified_no_write_R11: assert (!acc_we_o && !mem_we_o);
    if (rst_n && (op_i > OP_SKEXT || op_i == OP_NOP))
      assert_unused_quiet_R13: assert (!acc_we_o && !mem_we_o);
  end

endmodule

// File: tb/test_nib_alu_core.sv
module test_nib_alu_core;

  localparam logic [4:0] C_NOP = 5'd0,  C_ADD = 5'd1,  C_SUB = 5'd2,  C_AND = 5'd3;
  localparam logic [4:0] C_OR  = 5'd4,  C_XOR = 5'd5,  C_RRC = 5'd6,  C_RLC = 5'd7;
  localparam logic [4:0] C_RR  = 5'd8,  C_RL  = 5'd9,  C_INC = 5'd10, C_DEC = 5'd11;
  localparam logic [4:0] C_MAM = 5'd12, C_MMA = 5'd13, C_SETC = 5'd14, C_CLRC = 5'd15;
  localparam logic [4:0] C_SGT = 5'd16, C_SLT = 5'd17, C_SNE = 5'd18, C_SC0 = 5'd19;
  localparam logic [4:0] C_SZ0 = 5'd20, C_SC1 = 5'd21, C_SZ1 = 5'd22, C_SB0 = 5'd23;
  localparam logic [4:0] C_SEXT = 5'd24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op = 5'd0;
  logic [3:0] acc = 4'd0, opnd = 4'd0;
  logic [1:0] bsel = 2'd0;
  logic       ext = 1'b0;
  logic [3:0] res;
  logic       awe, mwe, carry, zero, skip;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] s_res;
  logic       s_awe, s_mwe;

  always #5 clk = ~clk;

  nib_alu_core i_nib_alu_core (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_i(op), .acc_i(acc),
    .opnd_i(opnd), .bit_sel_i(bsel), .ext_skip_i(ext), .res_o(res),
    .acc_we_o(awe), .mem_we_o(mwe), .carry_o(carry), .zero_o(zero), .skip_o(skip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [3:0] a, input logic [3:0] m,
                      input logic [1:0] b, input logic e);
    @(negedge clk);
    op = o; acc = a; opnd = m; bsel = b; ext = e; op_valid = 1'b1;
    #1;
    s_res = res; s_awe = awe; s_mwe = mwe;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic set_c(input logic c);
    step(c ? C_SETC : C_CLRC, 4'd0, 4'd0, 2'd0, 1'b0);
  endtask

  // applies an op that would otherwise write and set zero; checks it is void
  task automatic expect_nullified(input string tag);
    logic c0, z0;
    c0 = carry; z0 = zero;
    step(C_MMA, 4'd0, 4'd0, 2'd0, 1'b0);
    chk({tag, " R11 acc_we"}, s_awe, 0);
    chk({tag, " R11 mem_we"}, s_mwe, 0);
    chk({tag, " R11 carry"}, carry, c0);
    chk({tag, " R11 zero"}, z0 ? 1 : zero, z0 ? 1 : 0);
    chk({tag, " R11 skip clear"}, skip, 0);
  endtask

  task automatic t_reset;
    chk("R1 carry", carry, 0);
    chk("R1 zero", zero, 0);
    chk("R1 skip", skip, 0);
    chk("R1 acc_we", awe, 0);
    chk("R1 mem_we", mwe, 0);
  endtask

  task automatic t_add;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++) begin
          int s;
          set_c(c[0]);
          step(C_ADD, a[3:0], m[3:0], 2'd0, 1'b0);
          s = a + m + c;
          chk("R2 sum", s_res, s % 16);
          chk("R2 acc_we", s_awe, 1);
          chk("R2 carry", carry, (s > 15) ? 1 : 0);
          chk("R2 zero", zero, (s % 16 == 0) ? 1 : 0);
        end
  endtask

  task automatic t_sub;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++) begin
          int d;
          set_c(c[0]);
          step(C_SUB, a[3:0], m[3:0], 2'd0, 1'b0);
          d = a - m - (1 - c);
          chk("R3 diff", s_res, (d + 16) % 16);
          chk("R3 carry", carry, (d >= 0) ? 1 : 0);
          chk("R3 zero", zero, (((d + 16) % 16) == 0) ? 1 : 0);
        end
  endtask

  task automatic t_logic;
    set_c(1'b1);
    step(C_AND, 4'b1100, 4'b0011, 2'd0, 1'b0);
    chk("R4 and", s_res, 0); chk("R4 and zero", zero, 1); chk("R4 and carry", carry, 1);
    step(C_OR, 4'b1000, 4'b0001, 2'd0, 1'b0);
    chk("R4 or", s_res, 9); chk("R4 or zero", zero, 0); chk("R4 or carry", carry, 1);
    set_c(1'b0);
    step(C_XOR, 4'b1010, 4'b0110, 2'd0, 1'b0);
    chk("R4 xor", s_res, 12); chk("R4 xor carry", carry, 0); chk("R4 xor we", s_awe, 1);
    step(C_XOR, 4'b0101, 4'b0101, 2'd0, 1'b0);
    chk("R4 xor zero", zero, 1);
  endtask

  task automatic t_rotate;
    set_c(1'b0);
    step(C_RRC, 4'b1001, 4'd0, 2'd0, 1'b0);
    chk("R5 rrc", s_res, 4'b0100); chk("R5 rrc carry", carry, 1); chk("R5 rrc zero", zero, 0);
    step(C_RLC, 4'b1001, 4'd0, 2'd0, 1'b0);
    chk("R5 rlc", s_res, 4'b0011); chk("R5 rlc carry", carry, 1);
    set_c(1'b0);
    step(C_RLC, 4'b0000, 4'd0, 2'd0, 1'b0);
    chk("R5 rlc zero", zero, 1); chk("R5 rlc carry0", carry, 0);
    set_c(1'b1);
    step(C_RR, 4'b1001, 4'd0, 2'd0, 1'b0);
    chk("R6 rr", s_res, 4'b1100); chk("R6 rr carry", carry, 1); chk("R6 rr zero", zero, 1);
    step(C_RL, 4'b1001, 4'd0, 2'd0, 1'b0);
    chk("R6 rl", s_res, 4'b0011); chk("R6 rl we", s_awe, 1); chk("R6 rl zero", zero, 1);
  endtask

  task automatic t_incdec;
    step(C_INC, 4'd0, 4'd15, 2'd0, 1'b0);
    chk("R7 inc wrap", s_res, 0); chk("R7 inc mem_we", s_mwe, 1); chk("R7 inc acc_we", s_awe, 0);
    chk("R7 inc carry", carry, 1); chk("R7 inc zero", zero, 1);
    step(C_INC, 4'd0, 4'd7, 2'd0, 1'b0);
    chk("R7 inc", s_res, 8); chk("R7 inc carry0", carry, 0); chk("R7 inc zero0", zero, 0);
    step(C_DEC, 4'd0, 4'd0, 2'd0, 1'b0);
    chk("R7 dec wrap", s_res, 15); chk("R7 dec borrow", carry, 0); chk("R7 dec zero0", zero, 0);
    step(C_DEC, 4'd0, 4'd1, 2'd0, 1'b0);
    chk("R7 dec", s_res, 0); chk("R7 dec carry", carry, 1); chk("R7 dec zero", zero, 1);
  endtask

  task automatic t_move;
    set_c(1'b0);
    step(C_MMA, 4'd0, 4'd0, 2'd0, 1'b0);
    chk("R8 mma", s_awe, 1); chk("R8 mma zero", zero, 1); chk("R8 mma carry", carry, 0);
    step(C_MAM, 4'd5, 4'd0, 2'd0, 1'b0);
    chk("R8 mam", s_res, 5); chk("R8 mam mem_we", s_mwe, 1);
    chk("R8 mam zero", zero, 1); chk("R8 mam carry", carry, 0);
    step(C_SETC, 4'd0, 4'd0, 2'd0, 1'b0);
    chk("R8 setc", carry, 1); chk("R8 setc we", s_awe | s_mwe, 0);
    step(C_CLRC, 4'd0, 4'd0, 2'd0, 1'b0);
    chk("R8 clrc", carry, 0); chk("R8 clrc zero", zero, 1);
  endtask

  task automatic skip_case(input string tag, input logic [4:0] o, input logic [3:0] a,
                           input logic [3:0] m, input logic [1:0] b, input logic e,
                           input logic exp_skip);
    logic c0, z0;
    c0 = carry; z0 = zero;
    step(o, a, m, b, e);
    chk({tag, " we"}, s_awe | s_mwe, 0);
    chk({tag, " skip"}, skip, exp_skip);
    chk({tag, " carry"}, carry, c0);
    chk({tag, " zero"}, zero, z0);
    if (exp_skip) expect_nullified(tag);
  endtask

  task automatic t_compare;
    skip_case("R9 gt true", C_SGT, 4'd5, 4'd3, 2'd0, 1'b0, 1'b1);
    skip_case("R9 gt equal", C_SGT, 4'd3, 4'd3, 2'd0, 1'b0, 1'b0);
    skip_case("R9 lt true", C_SLT, 4'd2, 4'd15, 2'd0, 1'b0, 1'b1);
    skip_case("R9 lt false", C_SLT, 4'd15, 4'd2, 2'd0, 1'b0, 1'b0);
    skip_case("R9 ne true", C_SNE, 4'd1, 4'd0, 2'd0, 1'b0, 1'b1);
    skip_case("R9 ne false", C_SNE, 4'd9, 4'd9, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_flag_skip;
    set_c(1'b1);
    step(C_MMA, 4'd0, 4'd0, 2'd0, 1'b0);
    skip_case("R10 c1 true", C_SC1, 4'd0, 4'd0, 2'd0, 1'b0, 1'b1);
    skip_case("R10 c0 false", C_SC0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0);
    skip_case("R10 z1 true", C_SZ1, 4'd0, 4'd0, 2'd0, 1'b0, 1'b1);
    skip_case("R10 z0 false", C_SZ0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0);
    set_c(1'b0);
    step(C_MMA, 4'd0, 4'd6, 2'd0, 1'b0);
    skip_case("R10 c0 true", C_SC0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b1);
    skip_case("R10 z0 true", C_SZ0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b1);
    skip_case("R10 bit2 clear", C_SB0, 4'b1011, 4'd0, 2'd2, 1'b0, 1'b1);
    skip_case("R10 bit0 set", C_SB0, 4'b1011, 4'd0, 2'd0, 1'b0, 1'b0);
    skip_case("R10 ext true", C_SEXT, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1);
    skip_case("R10 ext false", C_SEXT, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_skip_window;
    step(C_SNE, 4'd1, 4'd2, 2'd0, 1'b0);
    chk("R11 armed", skip, 1);
    step(C_SNE, 4'd1, 4'd2, 2'd0, 1'b0);
    chk("R11 nested skip void", skip, 0);
    chk("R11 nested we", s_awe | s_mwe, 0);
    set_c(1'b0);
    step(C_ADD, 4'd2, 4'd3, 2'd0, 1'b0);
    chk("R11 resumes", s_awe, 1);
    chk("R11 resumes sum", s_res, 5);
  endtask

  task automatic t_idle;
    step(C_SGT, 4'd9, 4'd1, 2'd0, 1'b0);
    @(negedge clk);
    op = C_ADD; acc = 4'd15; opnd = 4'd15;
    #1;
    chk("R12 idle acc_we", awe, 0);
    chk("R12 idle mem_we", mwe, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R12 skip held", skip, 1);
    chk("R12 carry held", carry, 0);
    expect_nullified("R12 after idle");
  endtask

  task automatic t_unused;
    set_c(1'b1);
    step(C_MMA, 4'd0, 4'd4, 2'd0, 1'b0);
    for (int k = 25; k < 33; k++) begin
      logic [4:0] code;
      code = (k == 32) ? C_NOP : k[4:0];
      step(code, 4'd0, 4'd0, 2'd0, 1'b1);
      chk("R13 unused we", s_awe | s_mwe, 0);
      chk("R13 unused carry", carry, 1);
      chk("R13 unused zero", zero, 0);
      chk("R13 unused skip", skip, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_incdec();
    t_move();
    t_compare();
    t_flag_skip();
    t_skip_window();
    t_idle();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule